// File: doc/BRIEF.md
# Dual-Mode Multiplexed Host Bus Port

This block is the peripheral side of an 8-bit multiplexed address/data host bus. The bus pins are an address strobe, an active-low chip select, two control pins and a mode pin. The mode pin sets how the two control pins are read. With the mode pin high, the first control pin is a data strobe and the second is a read/write level. With the mode pin low, the first control pin is an active-low read enable and the second is an active-low write strobe. All pins are asynchronous to the block. They are synchronised into a faster system clock and then decoded from their edges.

The block captures a 7-bit location from the bus on the falling edge of the address strobe. It turns each qualified strobe into one single-cycle read or write enable towards a register file. For a read it holds the returned byte and presents it with a separate output enable for as long as the host strobe lasts. Writes to protected locations are filtered, or partly masked, before they reach the register file. A completed read of the flag location raises a one-cycle side-effect pulse, so that the flags can clear after the host has seen them. A power-fail input or a low host reset pin shuts off every access.

Top module: `mbus_host_if`

## Requirements
- R1: On a falling edge of the address strobe, bits 6..0 of the bus become the latched location `reg_addr`, whether chip select is active or not.
- R2: Mode pin high, read: a rising data strobe with the read/write level high gives exactly one `reg_rd` pulse. The register-file byte for the latched location is then driven on `bus_out` with `bus_oe` high while the strobe stays high, and `bus_oe` returns low after the strobe falls.
- R3: Mode pin high, write: a falling data strobe with the read/write level low gives exactly one `reg_wr` pulse, and `reg_wdata` carries the bus byte seen while the strobe was high.
- R4: Mode pin low, read: the read pin going low gives exactly one `reg_rd` pulse. The byte is driven with `bus_oe` high while the pin stays low, and `bus_oe` drops after the pin returns high.
- R5: Mode pin low, write: the write pin returning high gives exactly one `reg_wr` pulse carrying the bus byte seen while it was low.
- R6: A strobe with chip select high produces no `reg_rd`, no `reg_wr` and no `bus_oe`.
- R7: While the power-fail input is high or the host reset pin is low, strobes produce no `reg_rd` and no `reg_wr`.
- R8: Locations 12 and 13 are read-only: a write strobe addressed to either produces no `reg_wr`.
- R9: A write to location 0 or location 10 carries `reg_wmask` = 0x7F, so that bit 7 is protected. A write to any other writable location carries `reg_wmask` = 0xFF.
- R10: `rd_clear` pulses for one cycle when a read of location 12 completes, meaning its strobe ends while the data is being driven. A read of any other location gives no pulse.
- R11: Each strobe yields at most one enable pulse, and `reg_rd` and `reg_wr` are never high in the same cycle.
- R12: After the synchronous reset, `bus_oe`, `reg_rd`, `reg_wr` and `rd_clear` are low and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the host strobes |
| rst | input | 1 | Synchronous active-high reset |
| pin_as | input | 1 | Address strobe; the location is captured on its falling edge |
| pin_cs_n | input | 1 | Chip select, active low |
| pin_ctl_a | input | 1 | Data strobe (mode high) or active-low read enable (mode low) |
| pin_ctl_b | input | 1 | Read/write level, high = read (mode high), or active-low write strobe (mode low) |
| pin_mode | input | 1 | Selects how the two control pins are interpreted |
| pin_pfail | input | 1 | Power-fail indication; high blocks all access |
| pin_hrst_n | input | 1 | Host reset pin, active low; low blocks all access |
| bus_in | input | 8 | Multiplexed address/data bus as seen at the pins |
| bus_out | output | 8 | Read data toward the bus |
| bus_oe | output | 1 | Output enable for `bus_out` |
| reg_addr | output | 7 | Latched register location |
| reg_rd | output | 1 | Single-cycle read enable to the register file |
| reg_wr | output | 1 | Single-cycle write enable to the register file |
| reg_wdata | output | 8 | Write data for the register file |
| reg_wmask | output | 8 | Per-bit write mask for the register file |
| reg_rdata | input | 8 | Register-file read data for `reg_addr`, valid in the `reg_rd` cycle |
| rd_clear | output | 1 | One-cycle pulse after a completed read of location 12 |

## Verification
The bench builds the block with three synchroniser stages instead of the default two. This lengthens every pin-to-enable path by one cycle and shows that the checks depend on windows, not on exact pulse cycles. Each host cycle in the vector table is held for several clocks per phase. This makes it possible to count the pulses each strobe produces and to inspect the driven byte in the middle of the strobe. Switching between the two modes from one table entry to the next exercises the idle level changes on the shared control pins. These changes must not be mistaken for strobes.

// File: rtl/mbhi_pkg.sv
package mbhi_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;

    // Locations with protection or side effects
    localparam logic [ADDR_W-1:0] LOC_SECONDS = 7'd0;
    localparam logic [ADDR_W-1:0] LOC_RATE    = 7'd10;
    localparam logic [ADDR_W-1:0] LOC_FLAGS   = 7'd12;
    localparam logic [ADDR_W-1:0] LOC_STATUS  = 7'd13;

    // Control pins after synchronisation, one bit each
    typedef struct packed {
        logic as_p;
        logic cs_n;
        logic ctl_a;
        logic ctl_b;
        logic mode;
        logic pfail;
        logic hrst_n;
    } ctl_pins_t;

    localparam int CTL_W = $bits(ctl_pins_t);

    // Decoded bus events of one system-clock cycle
    typedef struct packed {
        logic take_addr;
        logic rd_go;
        logic rd_stop;
        logic wr_go;
        logic blocked;
    } bus_ev_t;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_FETCH = 2'd1,
        RS_DRIVE = 2'd2
    } rd_state_t;

    // Bits a host write may change at a location; all zero = read-only
    function automatic logic [DATA_W-1:0] wr_mask_of(input logic [ADDR_W-1:0] loc);
        logic [DATA_W-1:0] m;
        if (loc == LOC_FLAGS || loc == LOC_STATUS)
            m = '0;
        else if (loc == LOC_SECONDS || loc == LOC_RATE)
            m = {1'b0, {(DATA_W-1){1'b1}}};
        else
            m = '1;
        return m;
    endfunction

    function automatic logic is_flag_loc(input logic [ADDR_W-1:0] loc);
        return loc == LOC_FLAGS;
    endfunction

endpackage

// File: rtl/mbhi_sync.sv
module mbhi_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= '0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbhi_decode.sv
module mbhi_decode
    import mbhi_pkg::*;
(
    input  ctl_pins_t cur,
    input  ctl_pins_t prv,
    output bus_ev_t   ev
);
    logic ok_cur, ok_prv, same_mode;
    logic a_rise, a_fall, b_rise;

    always_comb begin
        ok_cur    = !cur.cs_n && !cur.pfail && cur.hrst_n;
        ok_prv    = !prv.cs_n && !prv.pfail && prv.hrst_n;
        same_mode = (cur.mode == prv.mode);
        a_rise    = !prv.ctl_a &&  cur.ctl_a;
        a_fall    =  prv.ctl_a && !cur.ctl_a;
        b_rise    = !prv.ctl_b &&  cur.ctl_b;

        ev.take_addr = prv.as_p && !cur.as_p;
        ev.blocked   = cur.pfail || !cur.hrst_n;

        if (cur.mode) begin
            // strobe plus direction level
            ev.rd_go   = a_rise && cur.ctl_b && ok_cur && same_mode;
            ev.rd_stop = a_fall;
            ev.wr_go   = a_fall && !prv.ctl_b && ok_prv && same_mode;
        end else begin
            // separate active-low read and write strobes
            ev.rd_go   = a_fall && ok_cur && same_mode;
            ev.rd_stop = a_rise;
            ev.wr_go   = b_rise && ok_prv && same_mode;
        end
    end
endmodule

// File: rtl/mbhi_access.sv
module mbhi_access
    import mbhi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [DATA_W-1:0] bus_prv,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_wmask,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              rd_clear
);
    rd_state_t         st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] hold_q, wdata_q, wmask_q, cur_mask;
    logic              wr_q, clr_q, flag_rd_q;

    assign cur_mask = wr_mask_of(addr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= RS_IDLE;
            addr_q    <= '0;
            hold_q    <= '0;
            wdata_q   <= '0;
            wmask_q   <= '0;
            wr_q      <= 1'b0;
            clr_q     <= 1'b0;
            flag_rd_q <= 1'b0;
        end else begin
            wr_q  <= 1'b0;
            clr_q <= 1'b0;

            if (ev.take_addr)
                addr_q <= bus_prv[ADDR_W-1:0];

            if (ev.wr_go && (cur_mask != '0)) begin
                wr_q    <= 1'b1;
                wdata_q <= bus_prv;
                wmask_q <= cur_mask;
            end

            case (st_q)
                RS_IDLE: begin
                    if (ev.rd_go) st_q <= RS_FETCH;
                end
                RS_FETCH: begin
                    hold_q    <= reg_rdata;
                    flag_rd_q <= is_flag_loc(addr_q);
                    st_q      <= (ev.blocked || ev.rd_stop) ? RS_IDLE : RS_DRIVE;
                end
                RS_DRIVE: begin
                    if (ev.blocked) begin
                        st_q <= RS_IDLE;
                    end else if (ev.rd_stop) begin
                        st_q  <= RS_IDLE;
                        clr_q <= flag_rd_q;
                    end
                end
                default: st_q <= RS_IDLE;
            endcase
        end
    end

    assign reg_addr  = addr_q;
    assign reg_rd    = (st_q == RS_FETCH);
    assign reg_wr    = wr_q;
    assign reg_wdata = wdata_q;
    assign reg_wmask = wmask_q;
    assign bus_oe    = (st_q == RS_DRIVE);
    assign bus_out   = bus_oe ? hold_q : '0;
    assign rd_clear  = clr_q;
endmodule

// File: rtl/mbus_host_if.sv
module mbus_host_if
    import mbhi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_as,
    input  logic              pin_cs_n,
    input  logic              pin_ctl_a,
    input  logic              pin_ctl_b,
    input  logic              pin_mode,
    input  logic              pin_pfail,
    input  logic              pin_hrst_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_wmask,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              rd_clear
);
    logic [CTL_W-1:0]  ctl_raw, ctl_sync;
    logic [DATA_W-1:0] bus_sync, bus_prv;
    ctl_pins_t         cur, prv;
    bus_ev_t           ev;

    assign ctl_raw = {pin_as, pin_cs_n, pin_ctl_a, pin_ctl_b, pin_mode, pin_pfail, pin_hrst_n};

    mbhi_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync_ctl (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_sync)
    );

    mbhi_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync_bus (
        .clk(clk), .rst(rst), .d(bus_in), .q(bus_sync)
    );

    assign cur = ctl_pins_t'(ctl_sync);

    always_ff @(posedge clk) begin
        if (rst) begin
            prv     <= '0;
            bus_prv <= '0;
        end else begin
            prv     <= cur;
            bus_prv <= bus_sync;
        end
    end

    mbhi_decode u_decode (.cur(cur), .prv(prv), .ev(ev));

    mbhi_access u_access (
        .clk(clk), .rst(rst), .ev(ev), .bus_prv(bus_prv), .reg_rdata(reg_rdata),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_wmask(reg_wmask),
        .bus_out(bus_out), .bus_oe(bus_oe), .rd_clear(rd_clear)
    );
endmodule

// File: rtl/mbus_host_if_chk.sv
module mbus_host_if_chk (
    input logic       clk,
    input logic       rst,
    input logic [6:0] reg_addr,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [7:0] reg_wmask,
    input logic       bus_oe,
    input logic       rd_clear
);
    p_rd_single_r11: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);

    p_wr_single_r11: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    p_no_both_r11: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_wr));

    p_read_only_r8: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (reg_addr != 7'd12 && reg_addr != 7'd13));

    p_bit7_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr == 7'd0 || reg_addr == 7'd10)) |-> !reg_wmask[7]);

    p_oe_after_rd_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(reg_rd));

    p_clear_at_end_r10: assert property (@(posedge clk) disable iff (rst)
        rd_clear |-> $fell(bus_oe));
endmodule

bind mbus_host_if mbus_host_if_chk u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wmask(reg_wmask), .bus_oe(bus_oe), .rd_clear(rd_clear)
);

// File: tb/test_mbus_host_if.sv
module test_mbus_host_if;
    localparam int CLK_PERIOD = 10;
    localparam int STAGES     = 3;
    localparam int HOLD       = 8;
    localparam int NVEC       = 14;

    // {mode, cs_n, write, addr[6:0], data[7:0], exp_rd, exp_wr, exp_mask[7:0], exp_clr}
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 7'd5,   8'h00, 1'b1, 1'b0, 8'h00, 1'b0},
        {1'b1, 1'b0, 1'b1, 7'd5,   8'h3C, 1'b0, 1'b1, 8'hFF, 1'b0},
        {1'b0, 1'b0, 1'b0, 7'd33,  8'h00, 1'b1, 1'b0, 8'h00, 1'b0},
        {1'b0, 1'b0, 1'b1, 7'd100, 8'hC3, 1'b0, 1'b1, 8'hFF, 1'b0},
        {1'b1, 1'b0, 1'b1, 7'd0,   8'hFF, 1'b0, 1'b1, 8'h7F, 1'b0},
        {1'b0, 1'b0, 1'b1, 7'd10,  8'h81, 1'b0, 1'b1, 8'h7F, 1'b0},
        {1'b1, 1'b0, 1'b1, 7'd12,  8'h55, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b0, 1'b0, 1'b1, 7'd13,  8'hAA, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b1, 1'b0, 1'b0, 7'd12,  8'h00, 1'b1, 1'b0, 8'h00, 1'b1},
        {1'b0, 1'b0, 1'b0, 7'd12,  8'h00, 1'b1, 1'b0, 8'h00, 1'b1},
        {1'b1, 1'b1, 1'b0, 7'd77,  8'h00, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b0, 1'b1, 1'b1, 7'd20,  8'h11, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b0, 1'b0, 1'b0, 7'd13,  8'h00, 1'b1, 1'b0, 8'h00, 1'b0},
        {1'b1, 1'b0, 1'b0, 7'd127, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_as = 1'b0, pin_cs_n = 1'b1, pin_ctl_a = 1'b0, pin_ctl_b = 1'b1;
    logic       pin_mode = 1'b1, pin_pfail = 1'b0, pin_hrst_n = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out, reg_wdata, reg_wmask, reg_rdata;
    logic [6:0] reg_addr;
    logic       bus_oe, reg_rd, reg_wr, rd_clear;

    int errors = 0;
    int checks = 0;
    int n_rd = 0, n_wr = 0, n_clr = 0;
    logic [7:0] last_wdata = 8'h00, last_wmask = 8'h00;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Register-file model: each location returns a fixed pattern
    function automatic logic [7:0] model_byte(input logic [6:0] a);
        return {1'b1, a} ^ 8'h5A;
    endfunction
    assign reg_rdata = model_byte(reg_addr);

    mbus_host_if #(.SYNC_STAGES(STAGES)) i_mbus_host_if (
        .clk(clk), .rst(rst), .pin_as(pin_as), .pin_cs_n(pin_cs_n),
        .pin_ctl_a(pin_ctl_a), .pin_ctl_b(pin_ctl_b), .pin_mode(pin_mode),
        .pin_pfail(pin_pfail), .pin_hrst_n(pin_hrst_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_wmask(reg_wmask),
        .reg_rdata(reg_rdata), .rd_clear(rd_clear)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (reg_rd)   n_rd  <= n_rd + 1;
            if (rd_clear) n_clr <= n_clr + 1;
            if (reg_wr) begin
                n_wr       <= n_wr + 1;
                last_wdata <= reg_wdata;
                last_wmask <= reg_wmask;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string tag_of(input logic mode, input logic csn,
                                     input logic wr, input logic [6:0] a);
        if (csn)                              return "R6";
        if (wr && (a == 7'd12 || a == 7'd13)) return "R8";
        if (wr && (a == 7'd0  || a == 7'd10)) return "R9";
        if (wr)                               return mode ? "R3" : "R5";
        if (a == 7'd12)                       return "R10";
        return mode ? "R2" : "R4";
    endfunction

    // One complete host bus cycle with checks on its outcome
    task automatic bus_cycle(input logic mode, input logic csn, input logic wr,
                             input logic [6:0] a, input logic [7:0] d,
                             input logic erd, input logic ewr,
                             input logic [7:0] emask, input logic eclr,
                             input string tag);
        int rd0, wr0, clr0;
        pin_mode  = mode;
        pin_ctl_a = mode ? 1'b0 : 1'b1;
        pin_ctl_b = 1'b1;
        idle(HOLD);
        rd0 = n_rd; wr0 = n_wr; clr0 = n_clr;
        pin_cs_n = csn;
        bus_in   = {1'b0, a};
        pin_as   = 1'b1;
        idle(HOLD);
        pin_as = 1'b0;
        idle(HOLD);
        chk(reg_addr == a, "R1", "latched location", reg_addr, a);
        bus_in = wr ? d : 8'hEE;
        if (mode) begin
            pin_ctl_b = ~wr;
            idle(2);
            pin_ctl_a = 1'b1;
        end else if (wr) begin
            pin_ctl_b = 1'b0;
        end else begin
            pin_ctl_a = 1'b0;
        end
        idle(HOLD);
        if (!wr) begin
            chk(bus_oe == erd, tag, "output enable during strobe", bus_oe, erd);
            if (erd)
                chk(bus_out == model_byte(a), tag, "read byte", bus_out, model_byte(a));
        end
        if (mode)    pin_ctl_a = 1'b0;
        else if (wr) pin_ctl_b = 1'b1;
        else         pin_ctl_a = 1'b1;
        idle(HOLD);
        pin_ctl_b = 1'b1;
        pin_cs_n  = 1'b1;
        idle(HOLD);
        chk(bus_oe == 1'b0, tag, "output enable after strobe", bus_oe, 0);
        chk(n_rd - rd0 == int'(erd), {tag, " R11"}, "read pulses", n_rd - rd0, erd);
        chk(n_wr - wr0 == int'(ewr), {tag, " R11"}, "write pulses", n_wr - wr0, ewr);
        chk(n_clr - clr0 == int'(eclr), "R10", "clear pulses", n_clr - clr0, eclr);
        if (ewr) begin
            chk(last_wdata == d, tag, "write data", last_wdata, d);
            chk(last_wmask == emask, tag, "write mask", last_wmask, emask);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog: done=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(4);
        // R12: reset state
        chk(bus_oe == 1'b0,   "R12", "bus_oe in reset", bus_oe, 0);
        chk(reg_rd == 1'b0,   "R12", "reg_rd in reset", reg_rd, 0);
        chk(reg_wr == 1'b0,   "R12", "reg_wr in reset", reg_wr, 0);
        chk(rd_clear == 1'b0, "R12", "rd_clear in reset", rd_clear, 0);
        chk(reg_addr == 7'd0, "R12", "reg_addr in reset", reg_addr, 0);
        rst = 1'b0;
        idle(HOLD);
        chk(bus_oe == 1'b0 && reg_rd == 1'b0 && reg_wr == 1'b0, "R12",
            "idle after reset", {bus_oe, reg_rd, reg_wr}, 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [28:0] v;
            v = VEC[i];
            bus_cycle(v[28], v[27], v[26], v[25:19], v[18:11], v[10], v[9],
                      v[8:1], v[0], tag_of(v[28], v[27], v[26], v[25:19]));
        end

        // R7: power fail blocks a read in strobe mode
        pin_pfail = 1'b1;
        bus_cycle(1'b1, 1'b0, 1'b0, 7'd9, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, "R7");
        pin_pfail = 1'b0;
        // R7: host reset low blocks a write in separate-strobe mode
        pin_hrst_n = 1'b0;
        bus_cycle(1'b0, 1'b0, 1'b1, 7'd40, 8'h99, 1'b0, 1'b0, 8'h00, 1'b0, "R7");
        // R7: host reset low blocks a read of the flag location, so no clear
        bus_cycle(1'b1, 1'b0, 1'b0, 7'd12, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, "R7");
        pin_hrst_n = 1'b1;
        // access works again once released
        bus_cycle(1'b0, 1'b0, 1'b1, 7'd40, 8'h99, 1'b0, 1'b1, 8'hFF, 1'b0, "R5");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule